// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O peripheral that sits on a simple APB-style register bus. Software sets, for each pin, whether the pin drives the pad or only listens to it. It also chooses whether the pin belongs to software or to an alternate hardware function inside the chip. Pad input levels pass through a synchronizer. They can then be read back, and they feed an interrupt detector. That detector works per pin on rising edges, falling edges, both edges, or a high or low level. Its status is visible both raw and after the per-pin enable, and one combined interrupt line goes to the interrupt controller.

The data register does not use the usual read-modify-write scheme. Byte-address bits 9 down to 2 of any access inside the data window act as a per-bit mask. A write changes only the selected output bits. A read returns zero on every bit that was not selected. A driver can therefore set or sample one pin in a single bus access, and an interrupt handler and the main code can work on different pins without a lock.

The bus has no wait states and no error response. A write takes effect at the rising edge that ends its access phase. Read data is driven combinationally while the port is selected for a read. There is no streaming interface, so no back-pressure rules apply. The pad buses and the interrupt line are plain levels.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, the direction, mode, sense, both-edges, event, enable and output data registers are all zero, pad_oe is 0x00, pad_out is 0x00 and irq is low.
- R2: A read at any byte offset from 0x000 to 0x3FC (bits 11:10 zero) returns, in bit n, the synchronized level of pin n when address bit n+2 is 1, and 0 when it is 0.
- R3: A write in that same data window updates output data bit n only when address bit n+2 is 1. Every other data bit keeps its value, so offset 0x004 alone reaches pin 0 and 0x200 alone reaches pin 7.
- R4: The direction register at 0x400 (bit n = pin n, 1 = output) drives pad_oe[n] for a pin in software mode, and pad_out[n] then carries output data bit n.
- R5: The mode register at 0x420 hands pin n to hardware when bit n is 1. pad_out[n] and pad_oe[n] then follow alt_out[n] and alt_oe[n], whatever the direction and data registers hold.
- R6: A pin change becomes visible in data reads after exactly two rising clock edges: it is not visible after one.
- R7: With sense bit 0 (register 0x404), a pin detects edges. Both-edges bit 1 (0x408) catches either edge. Otherwise event bit 1 (0x40C) catches rising edges and 0 catches falling edges. A detected edge sets raw status bit n (read at 0x414), which stays set.
- R8: With sense bit 1, raw status bit n is live and not latched. It is 1 while the synchronized pin equals event bit n (1 = high level, 0 = low level).
- R9: Writing the clear register (0x41C) resets each edge-latched raw status bit whose data bit is 1. Bits written 0 are left alone. An edge detected in the same cycle as its clear leaves the bit set.
- R10: Masked status (read at 0x418) equals raw status AND the enable register (0x410, 1 = unmasked), and irq is high exactly when any masked status bit is 1.
- R11: Writes to the raw and masked status offsets change nothing, and the clear register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Port selected for a bus transfer |
| bus_en | input | 1 | Access phase of the transfer |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte-address bits 11:2 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while selected for a read |
| pin_in | input | 8 | Pad input levels, asynchronous |
| alt_out | input | 8 | Alternate-function output values |
| alt_oe | input | 8 | Alternate-function output enables |
| pad_out | output | 8 | Value driven toward the pads |
| pad_oe | output | 8 | Pad output enables, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check, on every cycle, the properties that hold without any history: data-window reads never show an unselected bit, data writes never disturb unselected bits, a software-mode input pin is never driven, irq stays low while every enable is clear, and an edge-latched status bit never drops without a clear. The bench scenarios are needed for the behaviour that depends on a sequence of events. These are the two-edge synchronizer latency, the choice of edge type for each pin, live level status against latched edge status, clear colliding with other bits, and the alternate-function takeover checked against a random mix of register writes.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int unsigned PINS      = 8;
  localparam int unsigned WADDR_W   = 10;  // byte address bits 11:2
  localparam int unsigned MASK_LO   = 0;   // bit 2 of the byte address
  localparam int unsigned MASK_HI   = MASK_LO + PINS - 1;

  typedef logic [PINS-1:0] pin_vec_t;

  typedef enum logic [3:0] {
    RS_NONE,
    RS_DATA,
    RS_DIR,
    RS_SENSE,
    RS_BOTH,
    RS_EVENT,
    RS_IEN,
    RS_RAW,
    RS_MASKED,
    RS_CLEAR,
    RS_MODE
  } reg_sel_e;

  // Word-address decode; the whole lower quarter is the masked data window.
  function automatic reg_sel_e decode_addr(input logic [WADDR_W-1:0] wa);
    reg_sel_e r;
    if (wa[WADDR_W-1:WADDR_W-2] == 2'b00) begin
      r = RS_DATA;
    end else begin
      case (wa)
        10'h100: r = RS_DIR;
        10'h101: r = RS_SENSE;
        10'h102: r = RS_BOTH;
        10'h103: r = RS_EVENT;
        10'h104: r = RS_IEN;
        10'h105: r = RS_RAW;
        10'h106: r = RS_MASKED;
        10'h107: r = RS_CLEAR;
        10'h108: r = RS_MODE;
        default: r = RS_NONE;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/gpio_mask_sync.sv
module gpio_mask_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mask_regs.sv
module gpio_mask_regs
  import gpio_mask_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_en,
  input  logic               bus_write,
  input  logic [WADDR_W-1:0] bus_addr,
  input  pin_vec_t           bus_wdata,
  output pin_vec_t           bus_rdata,
  input  pin_vec_t           lvl,
  input  pin_vec_t           raw_st,
  input  pin_vec_t           masked_st,
  output pin_vec_t           data_q,
  output pin_vec_t           dir_q,
  output pin_vec_t           sense_q,
  output pin_vec_t           both_q,
  output pin_vec_t           event_q,
  output pin_vec_t           ien_q,
  output pin_vec_t           mode_q,
  output pin_vec_t           clr_vec
);
  reg_sel_e sel;
  logic     wr_stb;
  logic     rd_act;
  pin_vec_t addr_mask;

  assign sel       = decode_addr(bus_addr);
  assign wr_stb    = bus_sel && bus_en && bus_write;
  assign rd_act    = bus_sel && !bus_write;
  assign addr_mask = bus_addr[MASK_HI:MASK_LO];

  // Clear is a one-cycle pulse, not a stored register.
  assign clr_vec = (wr_stb && sel == RS_CLEAR) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      event_q <= '0;
      ien_q   <= '0;
      mode_q  <= '0;
    end else if (wr_stb) begin
      case (sel)
        RS_DATA:  data_q  <= (data_q & ~addr_mask) | (bus_wdata & addr_mask);
        RS_DIR:   dir_q   <= bus_wdata;
        RS_SENSE: sense_q <= bus_wdata;
        RS_BOTH:  both_q  <= bus_wdata;
        RS_EVENT: event_q <= bus_wdata;
        RS_IEN:   ien_q   <= bus_wdata;
        RS_MODE:  mode_q  <= bus_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_act) begin
      case (sel)
        RS_DATA:   bus_rdata = lvl & addr_mask;
        RS_DIR:    bus_rdata = dir_q;
        RS_SENSE:  bus_rdata = sense_q;
        RS_BOTH:   bus_rdata = both_q;
        RS_EVENT:  bus_rdata = event_q;
        RS_IEN:    bus_rdata = ien_q;
        RS_RAW:    bus_rdata = raw_st;
        RS_MASKED: bus_rdata = masked_st;
        RS_MODE:   bus_rdata = mode_q;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_mask_irq.sv
module gpio_mask_irq
  import gpio_mask_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_vec_t lvl,
  input  pin_vec_t sense,
  input  pin_vec_t both,
  input  pin_vec_t evt,
  input  pin_vec_t ien,
  input  pin_vec_t clr,
  output pin_vec_t raw_st,
  output pin_vec_t masked_st,
  output logic     irq
);
  pin_vec_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    logic rise, fall, hit, latch_q;

    assign rise = lvl[n] & ~prev_q[n];
    assign fall = ~lvl[n] & prev_q[n];
    assign hit  = both[n] ? (rise | fall) : (evt[n] ? rise : fall);

    // A new edge wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        latch_q <= 1'b0;
      else if (sense[n]) latch_q <= 1'b0;
      else               latch_q <= hit | (latch_q & ~clr[n]);
    end

    assign raw_st[n] = sense[n] ? (lvl[n] == evt[n]) : latch_q;
  end

  assign masked_st = raw_st & ien;
  assign irq       = |masked_st;
endmodule

// File: rtl/gpio_mask_pad.sv
module gpio_mask_pad
  import gpio_mask_pkg::*;
(
  input  pin_vec_t data_q,
  input  pin_vec_t dir_q,
  input  pin_vec_t mode_q,
  input  pin_vec_t alt_out,
  input  pin_vec_t alt_oe,
  output pin_vec_t pad_out,
  output pin_vec_t pad_oe
);
  for (genvar n = 0; n < PINS; n++) begin : g_pad
    assign pad_out[n] = mode_q[n] ? alt_out[n] : data_q[n];
    assign pad_oe[n]  = mode_q[n] ? alt_oe[n]  : dir_q[n];
  end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_en,
  input  logic        bus_write,
  input  logic [9:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [7:0]  pin_in,
  input  logic [7:0]  alt_out,
  input  logic [7:0]  alt_oe,
  output logic [7:0]  pad_out,
  output logic [7:0]  pad_oe,
  output logic        irq
);
  pin_vec_t lvl;
  pin_vec_t data_q, dir_q, sense_q, both_q, event_q, ien_q, mode_q;
  pin_vec_t clr_vec, raw_st, masked_st;

  gpio_mask_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
  );

  gpio_mask_regs regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_en(bus_en), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lvl(lvl), .raw_st(raw_st), .masked_st(masked_st),
    .data_q(data_q), .dir_q(dir_q), .sense_q(sense_q), .both_q(both_q),
    .event_q(event_q), .ien_q(ien_q), .mode_q(mode_q), .clr_vec(clr_vec)
  );

  gpio_mask_irq irq_i (
    .clk(clk), .rst_n(rst_n), .lvl(lvl),
    .sense(sense_q), .both(both_q), .evt(event_q), .ien(ien_q), .clr(clr_vec),
    .raw_st(raw_st), .masked_st(masked_st), .irq(irq)
  );

  gpio_mask_pad pad_i (
    .data_q(data_q), .dir_q(dir_q), .mode_q(mode_q),
    .alt_out(alt_out), .alt_oe(alt_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );
endmodule

// File: rtl/gpio_mask_chk.sv
module gpio_mask_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_en,
  input logic       bus_write,
  input logic [9:0] bus_addr,
  input logic [7:0] bus_rdata,
  input logic [7:0] data_q,
  input logic [7:0] dir_q,
  input logic [7:0] mode_q,
  input logic [7:0] ien_q,
  input logic [7:0] sense_q,
  input logic [7:0] raw_st,
  input logic [7:0] clr_vec,
  input logic [7:0] pad_oe,
  input logic       irq
);
  logic in_window;
  assign in_window = (bus_addr[9:8] == 2'b00);

  a_r2_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_write && in_window) |-> ((bus_rdata & ~bus_addr[7:0]) == 8'h00));

  a_r3_unselected_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_en && bus_write && in_window)
      |=> ((data_q & ~$past(bus_addr[7:0])) == ($past(data_q) & ~$past(bus_addr[7:0]))));

  a_r4_input_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~dir_q & ~mode_q) == 8'h00));

  a_r10_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 8'h00) |-> !irq);

  a_r9_latch_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == 8'h00)
      |=> ((($past(raw_st) & ~$past(sense_q) & ~sense_q) & ~raw_st) == 8'h00));
endmodule

bind gpio_mask_port gpio_mask_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en),
  .bus_write(bus_write), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .data_q(data_q), .dir_q(dir_q), .mode_q(mode_q), .ien_q(ien_q),
  .sense_q(sense_q), .raw_st(raw_st), .clr_vec(clr_vec),
  .pad_oe(pad_oe), .irq(irq)
);

// File: tb/gpio_mask_port_tb_top.sv
module gpio_mask_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_en = 1'b0, bus_write = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pin_in = '0, alt_out = '0, alt_oe = '0;
  logic [7:0] pad_out, pad_oe;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_mask_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .alt_out(alt_out),
    .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // Byte offsets used by the bench (see requirements).
  localparam logic [11:0] OFF_DIR = 12'h400, OFF_SENSE = 12'h404,
    OFF_BOTH = 12'h408, OFF_EVENT = 12'h40C, OFF_IEN = 12'h410,
    OFF_RAW = 12'h414, OFF_MASKED = 12'h418, OFF_CLEAR = 12'h41C,
    OFF_MODE = 12'h420;

  logic [7:0] m_data = '0, m_dir = '0, m_mode = '0;

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input logic [7:0] act, input logic [7:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic bus_wr(input logic [11:0] off, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_write = 1; bus_en = 0; bus_addr = off[11:2]; bus_wdata = d;
    @(negedge clk);
    bus_en = 1;
    @(negedge clk);
    bus_sel = 0; bus_en = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic [11:0] off, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_write = 0; bus_en = 0; bus_addr = off[11:2];
    @(negedge clk);
    bus_en = 1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_en = 0;
  endtask

  function automatic logic [7:0] exp_pad_out(input logic [7:0] dat, input logic [7:0] mode, input logic [7:0] ao);
    return (mode & ao) | (~mode & dat);
  endfunction

  function automatic logic [7:0] exp_pad_oe(input logic [7:0] dir, input logic [7:0] mode, input logic [7:0] aoe);
    return (mode & aoe) | (~mode & dir);
  endfunction

  function automatic logic [7:0] merge_masked(input logic [7:0] old, input logic [7:0] msk, input logic [7:0] w);
    return (old & ~msk) | (w & msk);
  endfunction

  task automatic data_wr(input logic [7:0] msk, input logic [7:0] w);
    bus_wr({2'b00, msk, 2'b00}, w);
    m_data = merge_masked(m_data, msk, w);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    void'($urandom(32'd20240611));

    // R1: reset state
    wait_cyc(3);
    #1;
    check_eq("R1 pad_oe in reset", pad_oe, 8'h00);
    check_eq("R1 pad_out in reset", pad_out, 8'h00);
    check_eq("R1 irq in reset", {7'd0, irq}, 8'h00);
    rst_n = 1;
    bus_rd(OFF_DIR, rd);   check_eq("R1 dir reset", rd, 8'h00);
    bus_rd(OFF_MODE, rd);  check_eq("R1 mode reset", rd, 8'h00);
    bus_rd(OFF_IEN, rd);   check_eq("R1 enable reset", rd, 8'h00);
    bus_rd(OFF_SENSE, rd); check_eq("R1 sense reset", rd, 8'h00);

    // R4 / R3 directed
    bus_wr(OFF_DIR, 8'hFF); m_dir = 8'hFF;
    data_wr(8'hFF, 8'hA5);
    #1 check_eq("R4 full write pad_out", pad_out, 8'hA5);
    check_eq("R4 pad_oe follows dir", pad_oe, 8'hFF);
    data_wr(8'h01, 8'h00);           // offset 0x004, pin 0 alone
    #1 check_eq("R3 pin0 alone", pad_out, 8'hA4);
    data_wr(8'h80, 8'h00);           // offset 0x200, pin 7 alone
    #1 check_eq("R3 pin7 alone", pad_out, 8'h24);
    data_wr(8'h00, 8'hFF);           // no bits selected
    #1 check_eq("R3 empty mask", pad_out, 8'h24);

    // R5 directed
    alt_out = 8'h3C; alt_oe = 8'hC3;
    bus_wr(OFF_MODE, 8'hF0); m_mode = 8'hF0;
    #1 check_eq("R5 alt pad_out", pad_out, 8'h34);
    check_eq("R5 alt pad_oe", pad_oe, 8'hCF);

    // Random mix of writes checked against the model (R3, R4, R5)
    for (int i = 0; i < 200; i++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0: data_wr(8'($urandom), 8'($urandom));
        1: begin m_dir = 8'($urandom); bus_wr(OFF_DIR, m_dir); end
        2: begin m_mode = 8'($urandom); bus_wr(OFF_MODE, m_mode); end
        default: begin @(negedge clk); alt_out = 8'($urandom); alt_oe = 8'($urandom); end
      endcase
      #1;
      check_eq("R3/R5 random pad_out", pad_out, exp_pad_out(m_data, m_mode, alt_out));
      check_eq("R4/R5 random pad_oe", pad_oe, exp_pad_oe(m_dir, m_mode, alt_oe));
    end

    // R2: random masked reads of settled pins
    for (int i = 0; i < 60; i++) begin
      logic [7:0] msk;
      @(negedge clk);
      pin_in = 8'($urandom);
      msk = 8'($urandom);
      wait_cyc(3);
      bus_rd({2'b00, msk, 2'b00}, rd);
      check_eq("R2 masked read", rd, pin_in & msk);
    end

    // R6: two-edge latency with the read held open
    @(negedge clk); pin_in = 8'h00;
    wait_cyc(3);
    bus_sel = 1; bus_write = 0; bus_en = 0; bus_addr = 10'h0FF;
    @(negedge clk);
    bus_en = 1; pin_in = 8'h5A;
    #1 check_eq("R6 no edge yet", bus_rdata, 8'h00);
    @(negedge clk); #1 check_eq("R6 one edge", bus_rdata, 8'h00);
    @(negedge clk); #1 check_eq("R6 two edges", bus_rdata, 8'h5A);
    @(negedge clk); bus_sel = 0; bus_en = 0;

    // R7 / R9 / R10 / R11: edge detection
    pin_in = 8'h00;
    bus_wr(OFF_SENSE, 8'h00);
    bus_wr(OFF_BOTH, 8'h01);         // pin0 either edge
    bus_wr(OFF_EVENT, 8'h02);        // pin1 rising, others falling
    bus_wr(OFF_IEN, 8'h00);
    wait_cyc(4);
    bus_wr(OFF_CLEAR, 8'hFF);
    bus_rd(OFF_RAW, rd); check_eq("R9 clear all", rd, 8'h00);
    @(negedge clk); pin_in = 8'h07;
    wait_cyc(4);
    bus_rd(OFF_RAW, rd); check_eq("R7 rising pass", rd, 8'h03);
    #1 check_eq("R10 irq off with no enable", {7'd0, irq}, 8'h00);
    @(negedge clk); pin_in = 8'h00;
    wait_cyc(4);
    bus_rd(OFF_RAW, rd); check_eq("R7 falling pass latched", rd, 8'h07);
    bus_wr(OFF_CLEAR, 8'h02);
    bus_rd(OFF_RAW, rd); check_eq("R9 clear pin1 only", rd, 8'h05);
    bus_wr(OFF_RAW, 8'hFF);
    bus_rd(OFF_RAW, rd); check_eq("R11 raw write ignored", rd, 8'h05);
    bus_rd(OFF_CLEAR, rd); check_eq("R11 clear reads zero", rd, 8'h00);
    bus_wr(OFF_IEN, 8'h04);
    bus_rd(OFF_MASKED, rd); check_eq("R10 masked status", rd, 8'h04);
    #1 check_eq("R10 irq on", {7'd0, irq}, 8'h01);
    bus_wr(OFF_MASKED, 8'h00);
    bus_rd(OFF_MASKED, rd); check_eq("R11 masked write ignored", rd, 8'h04);
    bus_wr(OFF_IEN, 8'h02);
    bus_rd(OFF_MASKED, rd); check_eq("R10 masked off", rd, 8'h00);
    #1 check_eq("R10 irq off", {7'd0, irq}, 8'h00);

    // R8: level detection on pin4
    bus_wr(OFF_SENSE, 8'h10);
    bus_wr(OFF_EVENT, 8'h10);
    bus_wr(OFF_CLEAR, 8'hFF);
    bus_rd(OFF_RAW, rd); check_eq("R8 high level, pin low", rd & 8'h10, 8'h00);
    @(negedge clk); pin_in = 8'h10;
    wait_cyc(3);
    bus_rd(OFF_RAW, rd); check_eq("R8 high level seen", rd, 8'h10);
    @(negedge clk); pin_in = 8'h00;
    wait_cyc(3);
    bus_rd(OFF_RAW, rd); check_eq("R8 level not latched", rd, 8'h00);
    bus_wr(OFF_EVENT, 8'h00);
    bus_rd(OFF_RAW, rd); check_eq("R8 low level seen", rd, 8'h10);

    done = 1;
    summary();
    $finish;
  end
endmodule